// File: doc/BRIEF.md
# Ethernet Frame Transmitter

This block turns a start request into a complete Ethernet frame on a byte-per-cycle stream. The stream is split into a rising-edge nibble and a falling-edge nibble, ready for a double-data-rate RGMII output stage, with a transmit-enable flag alongside. A frame is made of a seven-byte preamble, a start-of-frame delimiter, the destination and source MAC addresses, a payload and a CRC32 trailer. After the frame comes a programmable run of idle gap cycles.

Payload bytes come from one of two places. The first is an external byte-wide memory that has one cycle of read latency; the block drives its read address. The second is an external pseudo-random byte source, which the block advances with an enable strobe. The surrounding logic sets the payload size, the gap length, the payload source and both MAC addresses, then raises the start input. The phase-shifted transmit clock and the DDR output cells lie outside this block.

Top module: `eth_frame_tx`

## Requirements
- R1: A frame starts only on a rising edge of `start` seen while `busy` is low. Holding `start` high after a frame does not start another frame. A rising edge of `start` while `busy` is high is ignored.
- R2: Payload size, gap length, payload source select and both MAC addresses are captured at the accepted start edge. Changing them later has no effect on the frame in flight.
- R3: `tx_en` goes high two cycles after the start edge. The first bytes are seven bytes of 0x55 followed by one 0xD5 byte.
- R4: After the delimiter come the 48-bit destination address and then the 48-bit source address, each sent most significant byte first.
- R5: With the memory selected, payload byte k is the memory content at address k. The memory returns data one cycle after it samples `mem_addr`. A payload size of zero goes straight from the source address to the CRC.
- R6: Four CRC32 bytes follow the payload, least significant byte first. The CRC uses the reflected polynomial 0xEDB88320, an all-ones preset and final inversion, and covers the destination, source and payload bytes.
- R7: With the pseudo-random source selected, payload bytes are taken from `prng_byte`. `prng_en` is high for exactly one cycle per payload byte and at no other time.
- R8: After the last CRC byte, `tx_en` is low and both nibbles are zero. `busy` stays high for exactly the programmed gap count of cycles after `tx_en` falls.
- R9: `busy` rises one cycle after the accepted start edge, one cycle before `tx_en`, and stays high through the frame.
- R10: Each byte is driven as the low nibble on `txd_rise` and the high nibble on `txd_fall`.
- R11: While reset is held, `busy`, `tx_en`, `prng_en` and both nibble outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz byte clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Frame request; the rising edge is what counts |
| pay_len | input | 16 | Payload byte count |
| gap_len | input | 8 | Idle cycles held after the frame |
| use_prng | input | 1 | 1 selects the pseudo-random payload source |
| dst_mac | input | 48 | Destination address |
| src_mac | input | 48 | Source address |
| mem_addr | output | 16 | Payload memory read address |
| mem_data | input | 8 | Payload memory read data, one cycle after the address |
| prng_byte | input | 8 | Current pseudo-random byte |
| prng_en | output | 1 | Advance strobe for the pseudo-random source |
| busy | output | 1 | High from start through the end of the gap |
| tx_en | output | 1 | Transmit enable for the DDR stage |
| txd_rise | output | 4 | Nibble for the rising clock edge |
| txd_fall | output | 4 | Nibble for the falling clock edge |

## Verification
The assertions assume a payload memory that answers one cycle after it samples the address, and a `start` input that changes only between clock edges. The property that checks the address bound also assumes that the cached size stays fixed while a frame is in flight. The bench drives every input on the falling clock edge and models the memory as a registered read. It changes the size, addresses, gap and source select in the middle of a frame, and toggles `start` while `busy` is high, so the caching and edge rules are tested inside these assumptions. The pseudo-random source in the bench is a nonzero-seeded shift register that steps only on `prng_en`, so any extra or missing strobe shows up as a wrong byte or a wrong final state.

// File: rtl/eth_tx_pkg.sv
`timescale 1ns/1ps
package eth_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PRE  = 3'd1,
      ST_SFD  = 3'd2,
      ST_DST  = 3'd3,
      ST_SRC  = 3'd4,
      ST_PAY  = 3'd5,
      ST_FCS  = 3'd6,
      ST_GAP  = 3'd7
   } tx_state_e;

   localparam logic [7:0]  PRE_BYTE = 8'h55;
   localparam logic [7:0]  SFD_BYTE = 8'hD5;
   localparam logic [31:0] CRC_POLY = 32'hEDB88320;
   localparam int          FCS_BYTES = 4;

   // one byte through a reflected CRC32, LSB-first
   function automatic logic [31:0] crc_step(input logic [31:0] c_in,
                                            input logic [7:0]  b);
      logic [31:0] c;
      c = c_in ^ {24'd0, b};
      for (int i = 0; i < 8; i++) begin
         c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
      end
      return c;
   endfunction

endpackage

// File: rtl/eth_tx_crc.sv
`timescale 1ns/1ps
module eth_tx_crc
   import eth_tx_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        init,
   input  logic        en,
   input  logic [7:0]  din,
   output logic [31:0] fcs
);

   logic [31:0] crc_q;

   always_ff @(posedge clk) begin
      if (rst)       crc_q <= '1;
      else if (init) crc_q <= '1;
      else if (en)   crc_q <= crc_step(crc_q, din);
   end

   assign fcs = ~crc_q;

endmodule

// File: rtl/eth_tx_nibble_out.sv
`timescale 1ns/1ps
module eth_tx_nibble_out #(
   parameter bit LOW_NIB_RISE = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       en_i,
   input  logic [7:0] byte_i,
   output logic       en_o,
   output logic [3:0] rise_o,
   output logic [3:0] fall_o
);

   logic       en_q;
   logic [7:0] byte_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         en_q   <= 1'b0;
         byte_q <= 8'd0;
      end else begin
         en_q   <= en_i;
         byte_q <= byte_i;
      end
   end

   assign en_o = en_q;

   generate
      if (LOW_NIB_RISE) begin : g_low_rise
         assign rise_o = byte_q[3:0];
         assign fall_o = byte_q[7:4];
      end else begin : g_high_rise
         assign rise_o = byte_q[7:4];
         assign fall_o = byte_q[3:0];
      end
   endgenerate

endmodule

// File: rtl/eth_frame_tx.sv
`timescale 1ns/1ps
module eth_frame_tx
   import eth_tx_pkg::*;
#(
   parameter int LEN_W        = 16,
   parameter int GAP_W        = 8,
   parameter int MAC_W        = 48,
   parameter int PRE_LEN      = 7,
   parameter bit HAS_PRNG     = 1'b1,
   parameter bit LOW_NIB_RISE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [LEN_W-1:0] pay_len,
   input  logic [GAP_W-1:0] gap_len,
   input  logic             use_prng,
   input  logic [MAC_W-1:0] dst_mac,
   input  logic [MAC_W-1:0] src_mac,
   output logic [LEN_W-1:0] mem_addr,
   input  logic [7:0]       mem_data,
   input  logic [7:0]       prng_byte,
   output logic             prng_en,
   output logic             busy,
   output logic             tx_en,
   output logic [3:0]       txd_rise,
   output logic [3:0]       txd_fall
);

   localparam int MAC_BYTES = MAC_W / 8;
   localparam int SH_W      = 2 * MAC_W;
   localparam logic [LEN_W-1:0] ONE      = LEN_W'(1);
   localparam logic [LEN_W-1:0] PRE_LAST = LEN_W'(PRE_LEN - 1);
   localparam logic [LEN_W-1:0] MAC_LAST = LEN_W'(MAC_BYTES - 1);
   localparam logic [LEN_W-1:0] FCS_LAST = LEN_W'(FCS_BYTES - 1);

   generate
      if (MAC_W % 8 != 0 || MAC_W < 8) begin : g_bad_mac
         $error("MAC_W must be a nonzero multiple of 8");
      end
      if (LEN_W < GAP_W || LEN_W < 3) begin : g_bad_len
         $error("LEN_W must be at least GAP_W and at least 3");
      end
      if (PRE_LEN < 1) begin : g_bad_pre
         $error("PRE_LEN must be at least 1");
      end
   endgenerate

   tx_state_e        state_q;
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] len_q;
   logic [GAP_W-1:0] gap_q;
   logic             sel_q;
   logic [SH_W-1:0]  mac_sh;
   logic [LEN_W-1:0] addr_q;
   logic             start_q;
   logic             busy_d;
   logic             go;
   logic             cnt_end;
   logic [7:0]       pay_byte;
   logic [7:0]       cur_byte;
   logic [31:0]      fcs;
   logic             crc_en;
   logic             on_wire;

   assign go = (state_q == ST_IDLE) && !busy_d && start && !start_q;

   always_comb begin
      unique case (state_q)
         ST_PRE:  cnt_end = (cnt_q == PRE_LAST);
         ST_DST,
         ST_SRC:  cnt_end = (cnt_q == MAC_LAST);
         ST_PAY:  cnt_end = (cnt_q + ONE == len_q);
         ST_FCS:  cnt_end = (cnt_q == FCS_LAST);
         ST_GAP:  cnt_end = (cnt_q + ONE == LEN_W'(gap_q));
         default: cnt_end = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         len_q   <= '0;
         gap_q   <= '0;
         sel_q   <= 1'b0;
         mac_sh  <= '0;
         addr_q  <= '0;
         start_q <= 1'b0;
         busy_d  <= 1'b0;
      end else begin
         start_q <= start;
         busy_d  <= (state_q != ST_IDLE);
         cnt_q   <= cnt_end ? '0 : cnt_q + ONE;
         unique case (state_q)
            ST_IDLE: begin
               cnt_q <= '0;
               if (go) begin
                  state_q <= ST_PRE;
                  len_q   <= pay_len;
                  gap_q   <= gap_len;
                  sel_q   <= use_prng;
                  mac_sh  <= {dst_mac, src_mac};
                  addr_q  <= '0;
               end
            end
            ST_PRE:  if (cnt_end) state_q <= ST_SFD;
            ST_SFD:  state_q <= ST_DST;
            ST_DST: begin
               mac_sh <= mac_sh << 8;
               if (cnt_end) state_q <= ST_SRC;
            end
            ST_SRC: begin
               mac_sh <= mac_sh << 8;
               if (cnt_end) begin
                  addr_q  <= addr_q + ONE;
                  state_q <= (len_q == '0) ? ST_FCS : ST_PAY;
               end
            end
            ST_PAY: begin
               addr_q <= addr_q + ONE;
               if (cnt_end) state_q <= ST_FCS;
            end
            ST_FCS: if (cnt_end) state_q <= (gap_q == '0) ? ST_IDLE : ST_GAP;
            ST_GAP: if (cnt_end) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   generate
      if (HAS_PRNG) begin : g_prng
         assign pay_byte = sel_q ? prng_byte : mem_data;
         assign prng_en  = (state_q == ST_PAY) && sel_q;
      end else begin : g_mem_only
         assign pay_byte = mem_data;
         assign prng_en  = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (state_q)
         ST_PRE:  cur_byte = PRE_BYTE;
         ST_SFD:  cur_byte = SFD_BYTE;
         ST_DST,
         ST_SRC:  cur_byte = mac_sh[SH_W-1 -: 8];
         ST_PAY:  cur_byte = pay_byte;
         ST_FCS:  cur_byte = fcs[{cnt_q[1:0], 3'b000} +: 8];
         default: cur_byte = 8'd0;
      endcase
   end

   assign crc_en  = (state_q == ST_DST) || (state_q == ST_SRC) || (state_q == ST_PAY);
   assign on_wire = (state_q != ST_IDLE) && (state_q != ST_GAP);

   eth_tx_crc u_crc (
      .clk  (clk),
      .rst  (rst),
      .init (state_q == ST_SFD),
      .en   (crc_en),
      .din  (cur_byte),
      .fcs  (fcs)
   );

   eth_tx_nibble_out #(.LOW_NIB_RISE(LOW_NIB_RISE)) u_out (
      .clk    (clk),
      .rst    (rst),
      .en_i   (on_wire),
      .byte_i (cur_byte),
      .en_o   (tx_en),
      .rise_o (txd_rise),
      .fall_o (txd_fall)
   );

   assign mem_addr = addr_q;
   assign busy     = (state_q != ST_IDLE) || busy_d;

   // ---------------- assertions ----------------
   assert_start_edge_R1: assert property (@(posedge clk) disable iff (rst)
      (!busy && start && !start_q) |=> busy);

   assert_cache_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |->
         ($stable(len_q) && $stable(gap_q) && $stable(sel_q)));

   assert_addr_bound_R5: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_PAY) |-> (mem_addr <= len_q));

   assert_prng_on_wire_R7: assert property (@(posedge clk) disable iff (rst)
      prng_en |=> tx_en);

   assert_gap_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_GAP) |=> (!tx_en && txd_rise == 4'd0 && txd_fall == 4'd0));

   assert_busy_lead_R9: assert property (@(posedge clk) disable iff (rst)
      $rose(tx_en) |-> (busy && $past(busy)));

   assert_busy_cover_R9: assert property (@(posedge clk) disable iff (rst)
      tx_en |-> busy);

endmodule

// File: tb/test_eth_frame_tx.sv
`timescale 1ns/1ps
module test_eth_frame_tx;

   logic        clk = 1'b0;
   logic        rst;
   logic        start;
   logic [15:0] pay_len;
   logic [7:0]  gap_len;
   logic        use_prng;
   logic [47:0] dst_mac;
   logic [47:0] src_mac;
   logic [15:0] mem_addr;
   logic [7:0]  mem_data;
   logic [7:0]  prng_byte;
   logic        prng_en;
   logic        busy;
   logic        tx_en;
   logic [3:0]  txd_rise;
   logic [3:0]  txd_fall;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   eth_frame_tx i_eth_frame_tx (
      .clk(clk), .rst(rst), .start(start), .pay_len(pay_len), .gap_len(gap_len),
      .use_prng(use_prng), .dst_mac(dst_mac), .src_mac(src_mac),
      .mem_addr(mem_addr), .mem_data(mem_data), .prng_byte(prng_byte),
      .prng_en(prng_en), .busy(busy), .tx_en(tx_en),
      .txd_rise(txd_rise), .txd_fall(txd_fall)
   );

   // payload memory model with one cycle of read latency
   logic [7:0] mem [0:1023];
   always @(posedge clk) mem_data <= mem[mem_addr[9:0]];

   // pseudo-random source model, steps only on its strobe
   function automatic logic [7:0] prng_next(input logic [7:0] v);
      return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
   endfunction
   logic [7:0] lfsr;
   always @(posedge clk) begin
      if (rst) lfsr <= 8'h01;
      else if (prng_en) lfsr <= prng_next(lfsr);
   end
   assign prng_byte = lfsr;

   function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
      logic [31:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         logic fb;
         fb = r[0] ^ b[i];
         r  = r >> 1;
         if (fb) r = r ^ 32'hEDB88320;
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s act=0x%0h exp=0x%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic run_frame(input int n, input int g, input bit prng,
                            input logic [47:0] d, input logic [47:0] s, input bit disturb);
      logic [7:0]  q[$];
      logic [31:0] crc;
      logic [7:0]  p;
      logic [7:0]  b;
      int on_last;
      int busy_last;
      string tag;
      crc = 32'hFFFF_FFFF;
      p   = lfsr;
      for (int i = 0; i < 7; i++) q.push_back(8'h55);
      q.push_back(8'hD5);
      for (int i = 0; i < 6; i++) begin
         b = d[8*(5-i) +: 8]; q.push_back(b); crc = ref_crc(crc, b);
      end
      for (int i = 0; i < 6; i++) begin
         b = s[8*(5-i) +: 8]; q.push_back(b); crc = ref_crc(crc, b);
      end
      for (int i = 0; i < n; i++) begin
         if (prng) begin b = p; p = prng_next(p); end
         else b = mem[i];
         q.push_back(b); crc = ref_crc(crc, b);
      end
      crc = ~crc;
      for (int i = 0; i < 4; i++) q.push_back(crc[8*i +: 8]);

      pay_len  = 16'(n);
      gap_len  = 8'(g);
      use_prng = prng;
      dst_mac  = d;
      src_mac  = s;
      start    = 1'b1;
      on_last   = 25 + n;
      busy_last = 25 + n + g;

      for (int c = 1; c <= busy_last + 2; c++) begin
         @(negedge clk);
         check(busy == (c <= busy_last), (c == 1) ? "R9 busy" :
               (c > busy_last) ? "R1 busy" : "R8 busy", busy, c <= busy_last);
         if (c >= 2 && c <= on_last) begin
            int idx;
            idx = c - 2;
            if (idx < 8) tag = "R3 byte";
            else if (idx < 20) tag = "R4 byte";
            else if (idx < 20 + n) tag = prng ? "R7 byte" : "R5 byte";
            else tag = "R6 byte";
            check(tx_en == 1'b1, "R3 tx_en", tx_en, 1);
            check({txd_fall, txd_rise} == q[idx], tag, {txd_fall, txd_rise}, q[idx]);
            if (idx == 7) begin
               // R10: low nibble on rising edge, high nibble on falling edge
               check(txd_rise == 4'h5 && txd_fall == 4'hD, "R10 nibble order",
                     {txd_fall, txd_rise}, 8'hD5);
            end
         end else begin
            check(tx_en == 1'b0 && txd_rise == 4'd0 && txd_fall == 4'd0,
                  (c == 1) ? "R9 idle lead" : "R8 quiet",
                  {tx_en, txd_fall, txd_rise}, 0);
         end
         if (disturb && c == 3) begin
            // R2: new values after the start edge must not matter
            start    = 1'b0;
            pay_len  = pay_len + 16'd9;
            gap_len  = gap_len + 8'd5;
            use_prng = ~use_prng;
            dst_mac  = ~dst_mac;
            src_mac  = ~src_mac;
         end
         if (disturb && c == 5) start = 1'b1;
      end
      check(lfsr == p, "R7 strobe count", lfsr, p);
      start = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 37 + 11);
      rst = 1'b1; start = 1'b0; pay_len = '0; gap_len = '0; use_prng = 1'b0;
      dst_mac = '0; src_mac = '0;
      repeat (3) @(negedge clk);
      // R11: reset state
      check(!busy && !tx_en && !prng_en && txd_rise == 4'd0 && txd_fall == 4'd0,
            "R11 reset", {busy, tx_en, prng_en, txd_fall, txd_rise}, 0);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      run_frame(5, 3, 1'b0, 48'h0123_4567_89AB, 48'hA1B2_C3D4_E5F6, 1'b0);
      run_frame(0, 0, 1'b0, 48'hFFFF_FFFF_FFFF, 48'h0000_0000_0001, 1'b0);
      run_frame(12, 1, 1'b1, 48'h0200_0000_0042, 48'h0A0B_0C0D_0E0F, 1'b0);
      run_frame(3, 0, 1'b0, 48'h1111_2222_3333, 48'h4444_5555_6666, 1'b0);
      run_frame(6, 2, 1'b0, 48'hDEAD_BEEF_0001, 48'hCAFE_F00D_0002, 1'b1);
      run_frame(4, 4, 1'b1, 48'h5A5A_5A5A_5A5A, 48'hA5A5_A5A5_A5A5, 1'b1);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL R1 watchdog act=%0d exp=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule